// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block collects interrupt requests from a set of sources split into groups of 32. It latches each request into a per-group status register. It picks the most urgent pending source that is enabled and hands the processor a ready-to-jump handler address rather than an interrupt number. The default instance has four groups, for 128 sources in total. The parameter can go as high as eight groups under the register layout below.

Each group carries a one-bit mode selector:

- **Aggregated:** the whole group shares one programmable offset.
- **Disaggregated:** every source bit owns its offset, which gives a hardware jump table.

The handler address is a global base plus the chosen offset. Every source carries a two-bit priority.

The processor sees a request, address and priority triple. This triple holds until the processor acknowledges it. Firmware then clears the serviced status bit through the register port.

Top module: `grp_vec_intc`

## Requirements
- R1: After reset, irq_req is low and every register reads zero: base, mode, status, enable, priorities and offsets.
- R2: A source line that is high on a clock edge sets its status bit. Writing a 1 to a status bit (word address 0x040+4g) clears it. Bits written 0 are untouched. When a source is high in the same cycle that its bit is cleared, the bit stays set.
- R3: For group g, writing to 0x041+4g sets the enable bits given as 1, and writing to 0x042+4g clears them. Both addresses read back the enable word. The result word 0x043+4g reads status AND enable, and writes to it change nothing.
- R4: A request is raised only when some source is pending and enabled. irq_prio equals the highest priority among those sources, where level 3 is the most urgent and level 0 the least. The priority of group g, bit b sits in word 0x080+2g+(b/16), bits 2*(b%16)+1 down to 2*(b%16).
- R5: Among sources that share the top priority, the lower group index wins first, and then the lower bit index.
- R6: When the winning group has its mode bit clear (mode word at 0x001, bit g), irq_addr equals the base (word 0x000) plus that group's offset at 0x0C0+g.
- R7: When the winning group has its mode bit set, irq_addr equals the base plus the winning source's own offset at 0x100+32g+b.
- R8: Offset registers keep data bits 15:2 only. They read back with bits 1:0 and bits 31:16 as zero.
- R9: While irq_req is high and irq_ack is low, irq_req, irq_addr and irq_prio hold steady, even if the pending set changes. An acknowledge drops irq_req on the next edge. The edge after that makes a fresh selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NGRP*32 | Source lines; group g occupies bits 32g+31:32g |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_addr | output | 32 | Handler address for the request |
| irq_prio | output | 2 | Priority of the request |
| irq_ack | input | 1 | Processor acknowledge |

## Verification
Four properties are checked on every cycle:

- A high source line is never lost from status, including under a simultaneous clear.
- The request triple stays frozen until acknowledged.
- An acknowledge always drops the request.
- A request only rises after a cycle with some pending enabled source.

Whether the chosen source is actually the right one can only be shown by the bench's scenarios. This covers priority ordering, group-then-bit tie-breaks, and the mode-dependent address sum. The bench compares each request against a software model of randomly configured groups, and runs directed cases for register readback and the re-selection after an acknowledge.

// File: rtl/grp_vec_intc.sv
module grp_vec_intc #(
  parameter int NGRP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*32-1:0]   irq_src,
  input  logic                 reg_we,
  input  logic [8:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq_req,
  output logic [31:0]          irq_addr,
  output logic [1:0]           irq_prio,
  input  logic                 irq_ack
);
  localparam int GW = 32;
  localparam int HW = GW / 2;

  logic [31:0]     base_q;
  logic [NGRP-1:0] mode_q;
  logic [GW-1:0]   stat_q [NGRP];
  logic [GW-1:0]   en_q   [NGRP];
  logic [15:2]     agg_q  [NGRP];
  logic [1:0]      pri_q  [NGRP][GW];
  logic [15:2]     off_q  [NGRP][GW];

  wire       sel_base = reg_addr == 9'h000;
  wire       sel_mode = reg_addr == 9'h001;
  wire       sel_grp  = reg_addr[8:5] == 4'b0010;
  wire [2:0] grp_g    = reg_addr[4:2];
  wire [1:0] grp_k    = reg_addr[1:0];
  wire       sel_pri  = reg_addr[8:4] == 5'b01000;
  wire [2:0] pri_g    = reg_addr[3:1];
  wire       pri_h    = reg_addr[0];
  wire       sel_agg  = reg_addr[8:3] == 6'b011000;
  wire [2:0] agg_g    = reg_addr[2:0];
  wire       sel_off  = reg_addr[8];
  wire [2:0] off_g    = reg_addr[7:5];
  wire [4:0] off_b    = reg_addr[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= '0;
      for (int g = 0; g < NGRP; g++) begin
        stat_q[g] <= '0;
        en_q[g]   <= '0;
        agg_q[g]  <= '0;
        for (int b = 0; b < GW; b++) begin
          pri_q[g][b] <= '0;
          off_q[g][b] <= '0;
        end
      end
    end else begin
      if (reg_we && sel_base) base_q <= reg_wdata;
      if (reg_we && sel_mode) mode_q <= reg_wdata[NGRP-1:0];
      for (int g = 0; g < NGRP; g++) begin
        stat_q[g] <= (stat_q[g] &
                      ~((reg_we && sel_grp && int'(grp_g) == g && grp_k == 2'd0) ? reg_wdata : '0))
                     | irq_src[g*GW +: GW];
        if (reg_we && sel_grp && int'(grp_g) == g && grp_k == 2'd1)
          en_q[g] <= en_q[g] | reg_wdata;
        if (reg_we && sel_grp && int'(grp_g) == g && grp_k == 2'd2)
          en_q[g] <= en_q[g] & ~reg_wdata;
        if (reg_we && sel_agg && int'(agg_g) == g)
          agg_q[g] <= reg_wdata[15:2];
        for (int b = 0; b < GW; b++) begin
          if (reg_we && sel_pri && int'(pri_g) == g && (b / HW) == int'(pri_h))
            pri_q[g][b] <= reg_wdata[2*(b%HW) +: 2];
          if (reg_we && sel_off && int'(off_g) == g && int'(off_b) == b)
            off_q[g][b] <= reg_wdata[15:2];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_base) reg_rdata = base_q;
    if (sel_mode) reg_rdata[NGRP-1:0] = mode_q;
    for (int g = 0; g < NGRP; g++) begin
      if (sel_grp && int'(grp_g) == g) begin
        case (grp_k)
          2'd0:    reg_rdata = stat_q[g];
          2'd3:    reg_rdata = stat_q[g] & en_q[g];
          default: reg_rdata = en_q[g];
        endcase
      end
      if (sel_agg && int'(agg_g) == g) reg_rdata = {16'b0, agg_q[g], 2'b0};
      for (int b = 0; b < GW; b++) begin
        if (sel_pri && int'(pri_g) == g && (b / HW) == int'(pri_h))
          reg_rdata[2*(b%HW) +: 2] = pri_q[g][b];
        if (sel_off && int'(off_g) == g && int'(off_b) == b)
          reg_rdata = {16'b0, off_q[g][b], 2'b0};
      end
    end
  end

  logic        best_v;
  logic [1:0]  best_p;
  logic [15:2] best_off;

  always_comb begin
    best_v   = 1'b0;
    best_p   = '0;
    best_off = '0;
    for (int g = 0; g < NGRP; g++)
      for (int b = 0; b < GW; b++)
        if (stat_q[g][b] && en_q[g][b] && (!best_v || pri_q[g][b] > best_p)) begin
          best_v   = 1'b1;
          best_p   = pri_q[g][b];
          best_off = mode_q[g] ? off_q[g][b] : agg_q[g];
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_addr <= '0;
      irq_prio <= '0;
    end else if (irq_req) begin
      if (irq_ack) irq_req <= 1'b0;
    end else if (best_v) begin
      irq_req  <= 1'b1;
      irq_addr <= base_q + {16'b0, best_off, 2'b0};
      irq_prio <= best_p;
    end
  end

  logic [NGRP*GW-1:0] stat_flat;
  logic               res_any;
  always_comb begin
    res_any = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      stat_flat[g*GW +: GW] = stat_q[g];
      res_any = res_any | (|(stat_q[g] & en_q[g]));
    end
  end

  p_src_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src != '0) |=> ((stat_flat & $past(irq_src)) == $past(irq_src)));

  p_req_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(res_any));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_addr) && $stable(irq_prio)));

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
endmodule

// File: tb/grp_vec_intc_bench.sv
`timescale 1ns/1ps
module grp_vec_intc_bench;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*32-1:0] irq_src = '0;
  logic          reg_we = 1'b0;
  logic [8:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_req;
  logic [31:0]   irq_addr;
  logic [1:0]    irq_prio;
  logic          irq_ack = 1'b0;

  grp_vec_intc #(.NGRP(NG)) u_grp_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_addr(irq_addr), .irq_prio(irq_prio), .irq_ack(irq_ack));

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  bit [31:0] m_base;
  bit [NG-1:0] m_mode;
  bit [31:0] m_en [NG];
  bit [31:0] m_stat [NG];
  bit [1:0]  m_pri [NG][32];
  bit [15:0] m_agg [NG];
  bit [15:0] m_off [NG][32];

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit [8:0] a, input bit [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit [8:0] a, output logic [31:0] d);
    reg_addr = a; #0.2; d = reg_rdata;
  endtask

  task automatic write_pri(input int g);
    for (int h = 0; h < 2; h++) begin
      bit [31:0] w = 0;
      for (int i = 0; i < 16; i++) w[2*i +: 2] = m_pri[g][16*h+i];
      wr(9'(9'h080 + 2*g + h), w);
    end
  endtask

  task automatic write_off(input int g, input int b, input bit [15:0] v);
    m_off[g][b] = v & 16'hFFFC;
    wr(9'(9'h100 + 32*g + b), {$urandom} & 32'hFFFF0000 | 32'(v));
  endtask

  task automatic inject(input logic [NG*32-1:0] s);
    irq_src = s;
    tick();
    irq_src = '0;
    for (int g = 0; g < NG; g++) m_stat[g] |= s[g*32 +: 32];
  endtask

  task automatic cleanup();
    for (int g = 0; g < NG; g++) begin
      wr(9'(9'h042 + 4*g), 32'hFFFF_FFFF);
      wr(9'(9'h040 + 4*g), 32'hFFFF_FFFF);
      m_en[g] = 0; m_stat[g] = 0;
    end
    tick();
    if (irq_req) begin
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    end
    tick();
  endtask

  function automatic void pick(output bit v, output bit [1:0] p, output bit [31:0] a);
    v = 0; p = 0; a = 0;
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < 32; b++)
        if (m_stat[g][b] && m_en[g][b] && (!v || m_pri[g][b] > p)) begin
          v = 1; p = m_pri[g][b];
          a = m_base + 32'(m_mode[g] ? m_off[g][b] : m_agg[g]);
        end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit v; bit [1:0] p; bit [31:0] a;
    void'($urandom(32'd1234));
    m_base = 0; m_mode = 0;
    for (int g = 0; g < NG; g++) begin
      m_en[g] = 0; m_stat[g] = 0; m_agg[g] = 0;
      for (int b = 0; b < 32; b++) begin m_pri[g][b] = 0; m_off[g][b] = 0; end
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq_req", 32'(irq_req), 0);
    rd(9'h000, d); chk("R1 base", d, 0);
    rd(9'h001, d); chk("R1 mode", d, 0);
    rd(9'h044, d); chk("R1 status g1", d, 0);
    rd(9'h04D, d); chk("R1 enable g3", d, 0);
    rd(9'h083, d); chk("R1 prio g1 hi", d, 0);
    rd(9'h0C2, d); chk("R1 agg off g2", d, 0);
    rd(9'h17F, d); chk("R1 src off g3b31", d, 0);

    // R8 offset width and alignment
    wr(9'h0C1, 32'hFFFF_FFFF); m_agg[1] = 16'hFFFC;
    rd(9'h0C1, d); chk("R8 agg readback", d, 32'h0000_FFFC);
    write_off(2, 9, 16'h1237);
    rd(9'h149, d); chk("R8 src off readback", d, 32'h0000_1234);

    // R2 latching and write-1-to-clear
    inject(128'(32'h0000_0021) << 64);
    rd(9'h048, d); chk("R2 latched", d, 32'h21);
    irq_src = 128'(32'h0000_0020) << 64;
    wr(9'h048, 32'h0000_0020);
    irq_src = '0;
    rd(9'h048, d); chk("R2 set wins over clear", d, 32'h21);
    wr(9'h048, 32'h0000_0001); m_stat[2] = 32'h20;
    rd(9'h048, d); chk("R2 clear only ones", d, 32'h20);
    wr(9'h048, 32'hFFFF_FFFF); m_stat[2] = 0;
    rd(9'h048, d); chk("R2 cleared", d, 0);

    // R3 enable set/clear and result
    wr(9'h045, 32'h0000_00F0);
    wr(9'h046, 32'h0000_0030);
    rd(9'h045, d); chk("R3 enable set/clr", d, 32'hC0);
    rd(9'h046, d); chk("R3 enable alias", d, 32'hC0);
    inject(128'(32'h0000_0180) << 32);
    rd(9'h047, d); chk("R3 result", d, 32'h80);
    wr(9'h047, 32'hFFFF_FFFF);
    rd(9'h044, d); chk("R3 result write ignored", d, 32'h180);
    m_en[1] = 32'hC0;
    cleanup();
    chk("R4 idle after cleanup", 32'(irq_req), 0);

    // full offset table
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < 32; b++) write_off(g, b, 16'($urandom));
    m_base = 32'h8000_0000; wr(9'h000, m_base);

    // R5 tie-breaks
    m_mode = 4'b0110; wr(9'h001, 32'(m_mode));
    m_pri[1][7] = 2; m_pri[2][3] = 2; write_pri(1); write_pri(2);
    wr(9'h045, 32'hFFFF_FFFF); wr(9'h049, 32'hFFFF_FFFF);
    inject((128'(32'h80) << 32) | (128'(32'h8) << 64));
    tick();
    chk("R5 group tie addr", irq_addr, m_base + 32'(m_off[1][7]));
    chk("R5 group tie prio", 32'(irq_prio), 2);
    cleanup();
    m_pri[1][4] = 2; m_pri[1][9] = 2; write_pri(1);
    wr(9'h045, 32'hFFFF_FFFF);
    inject((128'(32'h210)) << 32);
    tick();
    chk("R5 bit tie addr", irq_addr, m_base + 32'(m_off[1][4]));
    cleanup();

    // R9 hold and reselection
    m_mode = 4'b1000; wr(9'h001, 32'(m_mode));
    m_pri[3][2] = 3; m_pri[3][10] = 1; write_pri(3);
    wr(9'h04D, 32'hFFFF_FFFF);
    inject(128'(32'h404) << 96);
    tick();
    chk("R9 first req", 32'(irq_req), 1);
    chk("R7 first addr", irq_addr, m_base + 32'(m_off[3][2]));
    chk("R4 first prio", 32'(irq_prio), 3);
    wr(9'h04C, 32'h4);
    inject(128'(32'h1) << 64);
    chk("R9 held req", 32'(irq_req), 1);
    chk("R9 held addr", irq_addr, m_base + 32'(m_off[3][2]));
    chk("R9 held prio", 32'(irq_prio), 3);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R9 ack drops", 32'(irq_req), 0);
    tick();
    chk("R9 reselect req", 32'(irq_req), 1);
    chk("R9 reselect addr", irq_addr, m_base + 32'(m_off[3][10]));
    chk("R9 reselect prio", 32'(irq_prio), 1);
    m_stat[3] = 0; m_stat[2] = 0;
    cleanup();

    // random scenarios: R4 R6 R7
    for (int it = 0; it < 60; it++) begin
      logic [NG*32-1:0] s;
      m_base = $urandom; wr(9'h000, m_base);
      m_mode = 4'($urandom); wr(9'h001, 32'(m_mode));
      for (int g = 0; g < NG; g++) begin
        for (int b = 0; b < 32; b++) m_pri[g][b] = 2'($urandom);
        write_pri(g);
        m_agg[g] = 16'($urandom) & 16'hFFFC;
        wr(9'(9'h0C0 + g), $urandom & 32'hFFFF0000 | 32'(m_agg[g]) | 32'($urandom % 4));
        m_en[g] = $urandom;
        wr(9'(9'h041 + 4*g), m_en[g]);
      end
      for (int k = 0; k < 4; k++) write_off(int'($urandom % NG), int'($urandom % 32), 16'($urandom));
      for (int g = 0; g < NG; g++) s[g*32 +: 32] = $urandom & $urandom & $urandom;
      inject(s);
      tick();
      pick(v, p, a);
      chk("R4 random req", 32'(irq_req), 32'(v));
      if (v) begin
        chk("R4 random prio", 32'(irq_prio), 32'(p));
        chk("R6 R7 random addr", irq_addr, a);
      end
      begin
        int g = int'($urandom % NG);
        rd(9'(9'h043 + 4*g), d);
        chk("R3 random result", d, m_stat[g] & m_en[g]);
      end
      cleanup();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule